// File: doc/BRIEF.md
# Privilege Level and Address Protection Guard

This block keeps the privilege state of a small processor core: a single level bit (low or high) and a protection-enable bit. Privilege can always be lowered by writing its register. It can only be raised through an arm-then-commit pair of register writes. The commit must come on the instruction right after the arm.

While protection is on and the core runs at low privilege, the block checks every instruction fetch address against a parameterised system-region boundary. It does the same check for every pointer activation made while the core executes out of RAM. A pointer activation means a write to either data pointer, the base pointer, the offset register or the pointer control register. The check happens at the moment of that write, because the write prefetches the addressed word.

A refused operation is reported the same cycle on `deny`, so the core can suppress its effect. The block then pulses `priv_irq` for one cycle on the next cycle. A sticky cause register records which kind of violation happened until software clears it.

Top module: `priv_guard`

## Requirements
- R1: After reset the level is high, the arm flag, the protection bit and all cause bits are 0, and `priv_irq` is 0.
- R2: A write of bit0=0 to the level register (select 0) always sets the level low. A write of bit0=1 at low level is refused: `deny` is 1 that cycle, the level stays low and cause bit0 is set.
- R3: A write of bit0=1 to the arm register (select 1) sets the arm flag. A write of bit0=1 to the commit register (select 2) while armed sets the level high.
- R4: Any other cycle with `instr_step`=1 clears the arm flag. A commit write of bit0=1 at low level without the arm flag is refused: `deny`=1, the level stays low and cause bit0 is set.
- R5: With protection on and the level low, a fetch whose address is below `SYS_BOUND` is denied and sets cause bit1. A fetch at or above `SYS_BOUND` is never denied.
- R6: With protection on, the level low and `ptr_from_ram`=1, a pointer activation below `SYS_BOUND` is denied and sets cause bit2. With `ptr_from_ram`=0 it is not checked.
- R7: With the protection bit 0, no fetch and no pointer activation is denied.
- R8: `priv_irq` is 1 exactly in the cycle after a cycle in which `deny` was 1.
- R9: Cause bits are sticky. Writing the cause register (select 4) clears the bits set in `reg_wdata[2:0]`. A bit set by a new violation in the same cycle stays set.
- R10: The protection bit (select 3, bit0) is written only at high level. A write at low level is refused: `deny`=1, the bit is unchanged and cause bit0 is set.
- R11: `rd_data` returns, zero-extended: select 0 the level, 1 the arm flag, 2 zero, 3 the protection bit, 4 the cause bits, any other select zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_step | input | 1 | An instruction retires this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| reg_wdata | input | 8 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Read data |
| fetch_valid | input | 1 | Code fetch request |
| fetch_addr | input | ADDR_W | Code fetch address |
| ptr_valid | input | 1 | Pointer activation request |
| ptr_addr | input | ADDR_W | Address the pointer resolves to |
| ptr_from_ram | input | 1 | Core is executing from RAM |
| deny | output | 1 | Current operation refused |
| priv_irq | output | 1 | One-cycle privilege exception pulse |
| priv_level | output | 1 | Current level, 1 = high |

## Verification
The bench builds the block with `ADDR_W`=10 and `SYS_BOUND`=256. With these values random addresses fall in system space about a quarter of the time, so both denied and allowed accesses come up often. The boundary addresses 255 and 256 are also reached directly. Arm/commit pairs are injected among the random traffic, so the level keeps moving between low and high. This lets every protection check be exercised at both levels and with protection both on and off.

// File: rtl/priv_guard_pkg.sv
// Shared register selects and cause bit positions for the privilege guard.
package priv_guard_pkg;
    localparam logic [2:0] SEL_LEVEL   = 3'd0;
    localparam logic [2:0] SEL_ARM     = 3'd1;
    localparam logic [2:0] SEL_COMMIT  = 3'd2;
    localparam logic [2:0] SEL_PROTECT = 3'd3;
    localparam logic [2:0] SEL_CAUSE   = 3'd4;

    localparam int CAUSE_W  = 3;
    localparam int C_WRITE  = 0;
    localparam int C_FETCH  = 1;
    localparam int C_PTR    = 2;
endpackage

// File: rtl/pg_level_ctrl.sv
// Holds the privilege level, the arm flag and the protection bit.
// Assumes a register write is part of the instruction retiring in the
// same cycle (instr_step is high alongside wr_en).
module pg_level_ctrl
    import priv_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       instr_step,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic       wr_bit,
    output logic       level_q,
    output logic       arm_q,
    output logic       prot_q,
    output logic       wr_refuse
);
    logic wr_level, wr_arm, wr_commit, wr_prot;

    // decode which register a write targets
    always_comb begin
        wr_level  = wr_en && (wr_sel == SEL_LEVEL);
        wr_arm    = wr_en && (wr_sel == SEL_ARM);
        wr_commit = wr_en && (wr_sel == SEL_COMMIT);
        wr_prot   = wr_en && (wr_sel == SEL_PROTECT);
    end

    // flag writes that would exceed the current level
    always_comb begin
        wr_refuse = 1'b0;
        if (!level_q) begin
            if (wr_level && wr_bit)             wr_refuse = 1'b1;
            if (wr_commit && wr_bit && !arm_q)  wr_refuse = 1'b1;
            if (wr_prot)                        wr_refuse = 1'b1;
        end
    end

    // level register: drop any time, raise only through an armed commit
    always_ff @(posedge clk) begin
        if (!rst_n)                         level_q <= 1'b1;
        else if (wr_level && !wr_bit)       level_q <= 1'b0;
        else if (wr_commit && wr_bit && arm_q) level_q <= 1'b1;
    end

    // arm flag lives for exactly one following instruction
    always_ff @(posedge clk) begin
        if (!rst_n)                  arm_q <= 1'b0;
        else if (wr_arm && wr_bit)   arm_q <= 1'b1;
        else if (instr_step || wr_en) arm_q <= 1'b0;
    end

    // protection enable, writable only at high level
    always_ff @(posedge clk) begin
        if (!rst_n)                 prot_q <= 1'b0;
        else if (wr_prot && level_q) prot_q <= wr_bit;
    end

    // R3
    level_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_q) |-> $past(wr_en && wr_sel == SEL_COMMIT));

    // R10
    prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PROTECT && !level_q) |=> $stable(prot_q));
endmodule

// File: rtl/pg_region_check.sv
// Compares one request address against the system-region boundary.
// Purely combinational; the caller supplies the enable that says whether
// the check applies at all (protection on, low level, etc.).
module pg_region_check #(
    parameter int ADDR_W    = 16,
    parameter int SYS_BOUND = 1024
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              check_en,
    output logic              deny
);
    localparam logic [ADDR_W:0] BOUND = (ADDR_W+1)'(SYS_BOUND);

    logic in_system;

    // deny a live request that falls in system space while checking applies
    always_comb begin
        in_system = {1'b0, req_addr} < BOUND;
        deny      = req_valid && check_en && in_system;
    end

    // R5
    always_comb begin
        if (req_valid && ({1'b0, req_addr} >= BOUND))
            user_space_chk: assert (deny !== 1'b1);
    end
endmodule

// File: rtl/pg_cause_log.sv
// Sticky violation cause bits with write-one-to-clear, and the registered
// one-cycle exception pulse. A new hit beats a clear in the same cycle.
module pg_cause_log
    import priv_guard_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] hit,
    input  logic               clr_en,
    input  logic [CAUSE_W-1:0] clr_mask,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               irq_q
);
    // keep causes until cleared, new hits win
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~(clr_en ? clr_mask : '0)) | hit;
    end

    // exception pulse one cycle after any hit
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |hit;
    end

    // R9
    cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (cause_q != '0));

    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> irq_q);
endmodule

// File: rtl/priv_guard.sv
// Privilege level and address protection guard. Combines the level
// controller, one region check for fetches and one for pointer
// activations, and the cause log. deny is combinational so the core can
// suppress the refused operation in the same cycle.
module priv_guard
    import priv_guard_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SYS_BOUND = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_step,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [7:0]        reg_wdata,
    input  logic [2:0]        rd_sel,
    output logic [7:0]        rd_data,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              ptr_valid,
    input  logic [ADDR_W-1:0] ptr_addr,
    input  logic              ptr_from_ram,
    output logic              deny,
    output logic              priv_irq,
    output logic              priv_level
);
    logic level_q, arm_q, prot_q, wr_refuse;
    logic fetch_deny, ptr_deny;
    logic [CAUSE_W-1:0] hit, cause_q;
    logic chk_fetch_en, chk_ptr_en;

    pg_level_ctrl u_level (
        .clk(clk), .rst_n(rst_n), .instr_step(instr_step),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_bit(reg_wdata[0]),
        .level_q(level_q), .arm_q(arm_q), .prot_q(prot_q),
        .wr_refuse(wr_refuse)
    );

    // checks apply only with protection on at low level
    always_comb begin
        chk_fetch_en = prot_q && !level_q;
        chk_ptr_en   = prot_q && !level_q && ptr_from_ram;
    end

    pg_region_check #(.ADDR_W(ADDR_W), .SYS_BOUND(SYS_BOUND)) u_fetch_chk (
        .req_valid(fetch_valid), .req_addr(fetch_addr),
        .check_en(chk_fetch_en), .deny(fetch_deny)
    );

    pg_region_check #(.ADDR_W(ADDR_W), .SYS_BOUND(SYS_BOUND)) u_ptr_chk (
        .req_valid(ptr_valid), .req_addr(ptr_addr),
        .check_en(chk_ptr_en), .deny(ptr_deny)
    );

    // gather violation kinds into cause bits
    always_comb begin
        hit          = '0;
        hit[C_WRITE] = wr_refuse;
        hit[C_FETCH] = fetch_deny;
        hit[C_PTR]   = ptr_deny;
        deny         = |hit;
    end

    pg_cause_log u_cause (
        .clk(clk), .rst_n(rst_n), .hit(hit),
        .clr_en(wr_en && wr_sel == SEL_CAUSE),
        .clr_mask(reg_wdata[CAUSE_W-1:0]),
        .cause_q(cause_q), .irq_q(priv_irq)
    );

    // register read mux
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_LEVEL:   rd_data[0] = level_q;
            SEL_ARM:     rd_data[0] = arm_q;
            SEL_PROTECT: rd_data[0] = prot_q;
            SEL_CAUSE:   rd_data[CAUSE_W-1:0] = cause_q;
            default:     rd_data = '0;
        endcase
    end

    assign priv_level = level_q;

    // R7
    prot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_q |-> !(fetch_deny || ptr_deny));

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_irq |-> $past(deny));
endmodule

// File: tb/priv_guard_tb.sv
module priv_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int BOUND = 256;

    logic clk = 0, rst_n = 0;
    logic instr_step = 0, wr_en = 0;
    logic [2:0] wr_sel = 0, rd_sel = 0;
    logic [7:0] reg_wdata = 0, rd_data;
    logic fetch_valid = 0, ptr_valid = 0, ptr_from_ram = 0;
    logic [AW-1:0] fetch_addr = 0, ptr_addr = 0;
    logic deny, priv_irq, priv_level;

    int n_run = 0, n_fail = 0;
    bit m_lvl, m_arm, m_prot, m_irq;
    bit [2:0] m_cause;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_guard #(.ADDR_W(AW), .SYS_BOUND(BOUND)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr_step(instr_step), .wr_en(wr_en),
        .wr_sel(wr_sel), .reg_wdata(reg_wdata), .rd_sel(rd_sel),
        .rd_data(rd_data), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .ptr_valid(ptr_valid), .ptr_addr(ptr_addr), .ptr_from_ram(ptr_from_ram),
        .deny(deny), .priv_irq(priv_irq), .priv_level(priv_level)
    );

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit [2:0] exp_hits();
        bit [2:0] h = 0;
        if (wr_en && !m_lvl) begin
            if (wr_sel == 0 && reg_wdata[0]) h[0] = 1;
            if (wr_sel == 2 && reg_wdata[0] && !m_arm) h[0] = 1;
            if (wr_sel == 3) h[0] = 1;
        end
        if (fetch_valid && m_prot && !m_lvl && fetch_addr < BOUND) h[1] = 1;
        if (ptr_valid && ptr_from_ram && m_prot && !m_lvl && ptr_addr < BOUND) h[2] = 1;
        return h;
    endfunction

    function automatic int exp_rd(bit [2:0] s);
        case (s)
            0: return int'(m_lvl);
            1: return int'(m_arm);
            3: return int'(m_prot);
            4: return int'(m_cause);
            default: return 0;
        endcase
    endfunction

    // one cycle: drive, check combinational outputs, clock, update model, check state
    task automatic cyc(bit st, bit we, bit [2:0] ws, bit [7:0] wd,
                       bit fv, int fa, bit pv, int pa, bit pr, bit [2:0] rs,
                       string tag);
        bit [2:0] h;
        @(negedge clk);
        instr_step = st | we; wr_en = we; wr_sel = ws; reg_wdata = wd;
        fetch_valid = fv; fetch_addr = AW'(fa); ptr_valid = pv;
        ptr_addr = AW'(pa); ptr_from_ram = pr; rd_sel = rs;
        #1;
        h = exp_hits();
        chk({tag, " R2/R4/R5/R6/R7/R10 deny"}, int'(deny), int'(h != 0));
        chk({tag, " R11 rd_data"}, int'(rd_data), exp_rd(rs));
        @(posedge clk);
        if (we && ws == 0 && !wd[0]) m_lvl = 0;
        else if (we && ws == 2 && wd[0] && m_arm) m_lvl = 1;
        if (we && ws == 1 && wd[0]) m_arm = 1; else if (instr_step) m_arm = 0;
        if (we && ws == 3 && (m_lvl || (ws == 3 && h[0] == 0))) m_prot = wd[0];
        m_cause = (m_cause & ~((we && ws == 4) ? wd[2:0] : 3'b0)) | h;
        m_irq = (h != 0);
        #1;
        chk({tag, " R8 irq"}, int'(priv_irq), int'(m_irq));
        chk({tag, " R2/R3 level"}, int'(priv_level), int'(m_lvl));
    endtask

    // write helper with no fetch/pointer traffic
    task automatic wr(bit [2:0] s, bit [7:0] d, string tag);
        cyc(1, 1, s, d, 0, 0, 0, 0, 0, s, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd9137));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        m_lvl = 1; m_arm = 0; m_prot = 0; m_irq = 0; m_cause = 0;
        #1;
        // R1 reset state
        chk("R1 level", int'(priv_level), 1);
        chk("R1 irq", int'(priv_irq), 0);
        rd_sel = 4; #1 chk("R1 cause", int'(rd_data), 0);
        rd_sel = 3; #1 chk("R1 prot", int'(rd_data), 0);
        rd_sel = 1; #1 chk("R1 arm", int'(rd_data), 0);

        // R7: protection off, everything allowed at low level
        wr(0, 0, "R2 drop");
        cyc(1, 0, 0, 0, 1, 5, 1, 7, 1, 4, "R7 off");
        // R2 refused raise
        wr(0, 1, "R2 raise refused");
        chk("R2 level stays low", int'(priv_level), 0);
        // R10 protect write at low refused
        wr(3, 1, "R10 low write");
        rd_sel = 3; #1 chk("R10 prot unchanged", int'(rd_data), 0);
        // R4 commit without arm
        wr(2, 1, "R4 commit unarmed");
        // R4 arm then intervening step then commit
        wr(1, 1, "R3 arm");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R4 step");
        wr(2, 1, "R4 stale commit");
        chk("R4 still low", int'(priv_level), 0);
        // R3 proper sequence
        wr(1, 1, "R3 arm");
        wr(2, 1, "R3 commit");
        chk("R3 raised", int'(priv_level), 1);
        wr(3, 1, "R10 high write");
        wr(0, 0, "R2 drop");
        // R5 boundary
        cyc(1, 0, 0, 0, 1, BOUND - 1, 0, 0, 0, 4, "R5 below");
        cyc(1, 0, 0, 0, 1, BOUND, 0, 0, 0, 4, "R5 at bound");
        // R6 from RAM vs not
        cyc(1, 0, 0, 0, 0, 0, 1, 3, 0, 4, "R6 not ram");
        cyc(1, 0, 0, 0, 0, 0, 1, 3, 1, 4, "R6 ram");
        // R9 clear with simultaneous new hit
        cyc(1, 1, 4, 8'h7, 1, 0, 0, 0, 0, 4, "R9 clear vs hit");
        wr(4, 8'h7, "R9 clear all");
        rd_sel = 4; #1 chk("R9 cleared", int'(rd_data), 0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int k = int'($urandom_range(0, 19));
            if (k == 0) begin
                wr(1, 1, "rnd R3 arm");
                wr(2, 1, "rnd R3 commit");
            end else if (k == 1) begin
                wr(0, 0, "rnd R2 drop");
            end else begin
                cyc(1'($urandom), 1'($urandom_range(0, 3) == 0),
                    3'($urandom_range(0, 5)), 8'($urandom),
                    1'($urandom), int'($urandom_range(0, 1023)),
                    1'($urandom), int'($urandom_range(0, 1023)),
                    1'($urandom), 3'($urandom_range(0, 6)), "rnd");
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule